// File: doc/BRIEF.md
# CPU interrupt and trap sequencer

This block is the exception-control unit of a small 16-bit processor with a two-stage fetch/execute pipeline and a byte-wide bus. It watches the reset, non-maskable interrupt and maskable interrupt pins and the break request from the decoder. At instruction boundaries it chooses the most urgent event and redirects fetch to a fixed vector. It never touches memory to do this. The return PC and the two status bits are copied into shadow flip-flops, and a one-cycle redirect pulse with a pipeline flush tells the fetch stage where to restart.

The block also executes the exception-related instructions once they retire: return from interrupt, moving the status, status shadow and return-PC shadow to and from a general register, clearing and setting the interrupt-disable bit, waiting for an interrupt and stopping. The vector table uses a 2-byte stride with the maskable interrupt slot last, so that handler can begin inline at its vector. The other slots hold a jump.

Top module: `trap_ctrl`

## Requirements
- R1: While `rst_n` is low the status reads I=1, T=0, `halt` and `redirect_valid` are 0. In the first cycle after `rst_n` returns high, a one-cycle redirect to 0x0000 is issued. During that cycle, events and operations are not acted on.
- R2: A falling edge on `nmi_n` is latched as pending until serviced and is taken regardless of I, with vector 0x0002. Holding `nmi_n` low produces no further entries.
- R3: A low level on `irq_n` is taken with vector 0x0006 only while I is 0.
- R4: Outside the wait state, events are sampled only in cycles where `insn_boundary` is 1.
- R5: When several events are ready at once, the order is NMI, then BRK (vector 0x0004), then IRQ. BRK is taken even when I is 1.
- R6: On taking an event, I and T are copied to the status shadow, `next_pc[15:1]` goes to the return-PC shadow and I is set to 1. In the following cycle `redirect_valid` and `flush` are 1 for exactly one cycle, and `redirect_pc` is the vector.
- R7: A retiring return-from-interrupt (`op_code` 1) restores I and T from the shadow. In the next cycle it redirects to the return-PC shadow with bit 0 clear.
- R8: The CSR selector maps 0 to status (bit 0 = I, bit 1 = T), 1 to the status shadow (same bit positions), 2 to the return-PC shadow (bits 15:1) and 3 to nothing. `csr_rdata` reflects the selected register combinationally, and code 3 reads 0. A retiring CSR write (`op_code` 3) loads the selected register from `csr_wdata`, and code 3 ignores the write. `op_code` 2 (CSR read) changes no state.
- R9: `op_code` 4 clears I, `op_code` 5 sets I, and neither changes T.
- R10: In a cycle where `op_valid` is 1, events are not sampled even if `insn_boundary` is 1. They are taken at a later boundary.
- R11: `op_code` 6 enters the wait state, which raises `halt`. Events are then sampled every cycle. A pending NMI, or a low `irq_n` with I=0, leaves the state by taking that event. BRK and masked IRQ do not wake it, and operations are ignored.
- R12: `op_code` 7 enters the stop state, which raises `halt`. Only reset leaves it. No event is taken and no operation is acted on while stopped.
- R13: Reset discards a pending NMI.
- R14: Bit 0 of `next_pc` and of a CSR write to the return-PC shadow is not stored, and reads of that shadow return bit 0 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset pin |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge triggered |
| irq_n | input | 1 | Maskable interrupt, active-low level |
| brk_req | input | 1 | Decoder reports a break instruction at the boundary |
| insn_boundary | input | 1 | Execute stage is at an instruction boundary |
| next_pc | input | 16 | PC to resume at after an entry |
| op_valid | input | 1 | An exception-related instruction retires |
| op_code | input | 3 | Operation: 0 none, 1 return, 2 CSR read, 3 CSR write, 4 clear I, 5 set I, 6 wait, 7 stop |
| csr_sel | input | 2 | CSR selector |
| csr_wdata | input | 16 | CSR write data from a general register |
| csr_rdata | output | 16 | Selected CSR value |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | 16 | Redirect target |
| flush | output | 1 | Discard the speculatively fetched instruction |
| halt | output | 1 | Core idles (wait or stop state) |

## Verification
The hardest situations to reach are the wait and stop states combined with pending events. In those states the NMI latch keeps filling while nothing is serviced, and reset must then discard the latched edge. The bench reaches them by retiring the wait or stop operation and then dropping `nmi_n` while stopped. It holds `nmi_n` low through a reset so that no new edge appears, then offers boundaries afterwards. A behavioural reference model, updated on every edge, is compared against all outputs in every cycle. Targeted checks cover priority collisions, where NMI, BRK and a low IRQ are all offered at the same boundary.

// File: rtl/trap_pkg.sv
// Shared types of the interrupt and trap sequencer.
// Assumes: status word is two bits, events are encoded by vector slot.
package trap_pkg;

    // Event identifiers; the value is also the vector slot index.
    typedef enum logic [1:0] {
        EV_RESET = 2'd0,
        EV_NMI   = 2'd1,
        EV_BRK   = 2'd2,
        EV_IRQ   = 2'd3
    } ev_e;

    // Retiring exception-related operations.
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_RETI = 3'd1,
        OP_CSRR = 3'd2,
        OP_CSRW = 3'd3,
        OP_CLI  = 3'd4,
        OP_SEI  = 3'd5,
        OP_WAI  = 3'd6,
        OP_STP  = 3'd7
    } op_e;

    // CSR selector codes.
    typedef enum logic [1:0] {
        CSR_STAT   = 2'd0,
        CSR_SHADOW = 2'd1,
        CSR_EPC    = 2'd2,
        CSR_NONE   = 2'd3
    } csr_e;

    // Status word: bit 0 interrupt disable, bit 1 general flag.
    typedef struct packed {
        logic t;
        logic i;
    } status_t;

    localparam int NUM_EVENTS = 4;

endpackage

// File: rtl/trap_nmi_latch.sv
// Falling-edge detector and pending latch for the non-maskable interrupt.
// Assumes: nmi_n is already synchronous to clk. A clear and a new edge in
// the same cycle leave the request pending.
module trap_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clear,
    output logic pend
);

    logic nmi_prev;
    logic fall;

    assign fall = nmi_prev & ~nmi_n;

    // Track the previous pin level and hold an edge until serviced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev <= nmi_n;
            pend     <= 1'b0;
        end else begin
            nmi_prev <= nmi_n;
            pend     <= fall | (pend & ~clear);
        end
    end

    // R2: an edge is always recorded.
    a_r2_fall_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_prev && !nmi_n) |=> pend);

    // R2: servicing without a new edge empties the latch.
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !(nmi_prev && !nmi_n)) |=> !pend);

endmodule

// File: rtl/trap_arbiter.sv
// Fixed-priority selection among NMI, BRK and IRQ at a sampling point.
// Assumes: reset is handled outside; sample is low while stopped.
module trap_arbiter
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic waiting,
    input  logic nmi_pend,
    input  logic brk_req,
    input  logic irq_n,
    input  logic stat_i,
    output logic take,
    output ev_e  ev
);

    localparam int NREQ = NUM_EVENTS;

    logic [NREQ-1:0] req;
    logic [NREQ-1:0] grant;

    // Ready conditions per slot; slot 0 (reset) is never requested here.
    always_comb begin
        req            = '0;
        req[EV_NMI]    = nmi_pend;
        req[EV_BRK]    = brk_req & ~waiting;
        req[EV_IRQ]    = ~irq_n & ~stat_i;
    end

    // Lowest slot index wins: NMI before BRK before IRQ.
    generate
        for (genvar k = 0; k < NREQ; k++) begin : g_prio
            if (k == 0) begin : g_first
                assign grant[k] = sample & req[k];
            end else begin : g_rest
                assign grant[k] = sample & req[k] & ~(|req[k-1:0]);
            end
        end
    endgenerate

    // Encode the single granted slot.
    always_comb begin
        ev = EV_RESET;
        for (int k = 0; k < NREQ; k++) begin
            if (grant[k]) ev = ev_e'(k);
        end
    end

    assign take = |grant;

    // R5: at most one event is granted.
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: nothing is taken outside a sampling point.
    a_r4_take_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> sample);

endmodule

// File: rtl/trap_state.sv
// Architectural exception state: status, status shadow, return-PC shadow,
// wait and stop flags, and the CSR read/write path.
// Assumes: take and op_fire are never high together.
module trap_state
    import trap_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  ev_e             ev,
    input  logic [XLEN-1:0] next_pc,
    input  logic            op_fire,
    input  op_e             op,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output status_t         stat,
    output status_t         shadow,
    output logic [XLEN-2:0] epc,
    output logic            waiting,
    output logic            stopped,
    output logic [XLEN-1:0] csr_rdata
);

    localparam int SW = $bits(status_t);

    csr_e sel;
    assign sel = csr_e'(csr_sel);

    // Status, shadows and idle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat    <= '{t: 1'b0, i: 1'b1};
            shadow  <= '0;
            epc     <= '0;
            waiting <= 1'b0;
            stopped <= 1'b0;
        end else if (take) begin
            shadow  <= stat;
            epc     <= next_pc[XLEN-1:1];
            stat.i  <= 1'b1;
            waiting <= 1'b0;
        end else if (op_fire) begin
            unique case (op)
                OP_RETI: stat <= shadow;
                OP_CSRW: begin
                    unique case (sel)
                        CSR_STAT:   stat   <= status_t'(csr_wdata[SW-1:0]);
                        CSR_SHADOW: shadow <= status_t'(csr_wdata[SW-1:0]);
                        CSR_EPC:    epc    <= csr_wdata[XLEN-1:1];
                        default:    ;
                    endcase
                end
                OP_CLI:  stat.i  <= 1'b0;
                OP_SEI:  stat.i  <= 1'b1;
                OP_WAI:  waiting <= 1'b1;
                OP_STP:  stopped <= 1'b1;
                default: ;
            endcase
        end
    end

    // Combinational CSR read mux.
    always_comb begin
        csr_rdata = '0;
        unique case (sel)
            CSR_STAT:   csr_rdata[SW-1:0] = stat;
            CSR_SHADOW: csr_rdata[SW-1:0] = shadow;
            CSR_EPC:    csr_rdata         = {epc, 1'b0};
            default:    csr_rdata         = '0;
        endcase
    end

    logic unused_ev;
    assign unused_ev = ^ev;

    // R1: reset leaves interrupts disabled and T clear.
    a_r1_reset_masks: assert property (@(posedge clk)
        !rst_n |=> (stat.i && !stat.t && !waiting && !stopped));

    // R12: stop persists until reset.
    a_r12_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> stopped);

    // R7: return restores the status from the shadow.
    a_r7_reti_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && op == OP_RETI) |=> (stat == $past(shadow)));

    // R6: entry masks interrupts and saves the old status.
    a_r6_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (stat.i && shadow == $past(stat)));

endmodule

// File: rtl/trap_ctrl.sv
// Interrupt and trap sequencer top: combines the NMI latch, the priority
// arbiter and the state registers, and drives the one-cycle fetch redirect.
// Assumes: inputs are synchronous; op_valid marks a retiring instruction.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int XLEN       = 16,
    parameter int VEC_BASE   = 0,
    parameter int VEC_STRIDE = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_n,
    input  logic            irq_n,
    input  logic            brk_req,
    input  logic            insn_boundary,
    input  logic [XLEN-1:0] next_pc,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            flush,
    output logic            halt
);

    logic [XLEN-1:0] vec_tab [NUM_EVENTS];

    // Vector table computed from base and stride.
    generate
        for (genvar k = 0; k < NUM_EVENTS; k++) begin : g_vec
            assign vec_tab[k] = XLEN'(VEC_BASE + k * VEC_STRIDE);
        end
    endgenerate

    logic            rst_pend;
    logic            nmi_pend;
    logic            sample;
    logic            take;
    ev_e             ev;
    logic            op_fire;
    op_e             op;
    status_t         stat;
    status_t         shadow;
    logic [XLEN-2:0] epc;
    logic            waiting;
    logic            stopped;

    assign op      = op_e'(op_code);
    assign sample  = ~rst_pend & ~stopped & (waiting | (insn_boundary & ~op_valid));
    assign op_fire = op_valid & ~waiting & ~stopped & ~rst_pend;

    // Reset entry is pending for the first cycle after release.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pend <= 1'b1;
        else        rst_pend <= 1'b0;
    end

    trap_nmi_latch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .clear (take && ev == EV_NMI),
        .pend  (nmi_pend)
    );

    trap_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .waiting  (waiting),
        .nmi_pend (nmi_pend),
        .brk_req  (brk_req),
        .irq_n    (irq_n),
        .stat_i   (stat.i),
        .take     (take),
        .ev       (ev)
    );

    trap_state #(.XLEN(XLEN)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .ev        (ev),
        .next_pc   (next_pc),
        .op_fire   (op_fire),
        .op        (op),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .stat      (stat),
        .shadow    (shadow),
        .epc       (epc),
        .waiting   (waiting),
        .stopped   (stopped),
        .csr_rdata (csr_rdata)
    );

    // Registered one-cycle redirect request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else if (rst_pend) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= vec_tab[EV_RESET];
        end else if (take) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= vec_tab[ev];
        end else if (op_fire && op == OP_RETI) begin
            redirect_valid <= 1'b1;
            redirect_pc    <= {epc, 1'b0};
        end else begin
            redirect_valid <= 1'b0;
        end
    end

    assign flush = redirect_valid;
    assign halt  = waiting | stopped;

    // R3: a maskable entry only happens while I is clear.
    a_r3_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ev == EV_IRQ) |-> !stat.i);

    // R6: every entry produces a redirect in the next cycle.
    a_r6_redirect_next: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_valid);

    // R12: a stopped core issues no redirect.
    a_r12_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !rst_pend) |=> !redirect_valid);

endmodule

// File: tb/trap_ctrl_bench.sv
`timescale 1ns/100ps
module trap_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n = 1'b1;
    logic        irq_n = 1'b1;
    logic        brk_req = 1'b0;
    logic        insn_boundary = 1'b0;
    logic [15:0] next_pc = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  csr_sel = '0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic        redirect_valid;
    logic [15:0] redirect_pc;
    logic        flush;
    logic        halt;

    always #2.5 clk = ~clk;

    trap_ctrl u_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .brk_req(brk_req), .insn_boundary(insn_boundary), .next_pc(next_pc),
        .op_valid(op_valid), .op_code(op_code), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .flush(flush), .halt(halt)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    // Behavioural reference state.
    bit m_i = 1, m_t = 0, m_si = 0, m_st = 0;
    int m_epc = 0;
    bit m_prev = 1, m_pend = 0, m_wait = 0, m_stop = 0, m_rstp = 1;
    bit m_rv = 0;
    int m_rpc = 0;

    // Reference update on every clock edge.
    always @(posedge clk) begin
        bit fall, took_nmi, smp;
        int ev;
        if (!rst_n) begin
            m_i = 1; m_t = 0; m_si = 0; m_st = 0; m_epc = 0;
            m_prev = nmi_n; m_pend = 0; m_wait = 0; m_stop = 0;
            m_rstp = 1; m_rv = 0;
        end else begin
            fall = m_prev && !nmi_n;
            took_nmi = 0;
            m_rv = 0;
            if (m_rstp) begin
                m_rv = 1; m_rpc = 0; m_rstp = 0;
            end else if (!m_stop) begin
                smp = m_wait || (insn_boundary && !op_valid);
                ev = -1;
                if (smp) begin
                    if (m_pend) ev = 1;
                    else if (brk_req && !m_wait) ev = 2;
                    else if (!irq_n && !m_i) ev = 3;
                end
                if (ev >= 0) begin
                    m_si = m_i; m_st = m_t; m_epc = next_pc / 2; m_i = 1;
                    m_rv = 1; m_rpc = ev * 2; m_wait = 0;
                    took_nmi = (ev == 1);
                end else if (op_valid && !m_wait) begin
                    case (op_code)
                        1: begin m_i = m_si; m_t = m_st; m_rv = 1; m_rpc = m_epc * 2; end
                        3: case (csr_sel)
                               0: begin m_i = csr_wdata[0]; m_t = csr_wdata[1]; end
                               1: begin m_si = csr_wdata[0]; m_st = csr_wdata[1]; end
                               2: m_epc = csr_wdata / 2;
                               default: ;
                           endcase
                        4: m_i = 0;
                        5: m_i = 1;
                        6: m_wait = 1;
                        7: m_stop = 1;
                        default: ;
                    endcase
                end
            end
            m_pend = fall || (m_pend && !took_nmi);
            m_prev = nmi_n;
        end
    end

    function automatic int m_rdata();
        case (csr_sel)
            0: return m_t * 2 + m_i;
            1: return m_st * 2 + m_si;
            2: return m_epc * 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // One clock, then compare every output against the model.
    task automatic step();
        @(posedge clk);
        #1;
        chk({redirect_valid, flush, halt}, {m_rv, m_rv, m_wait | m_stop}, "model rv/flush/halt");
        if (m_rv) chk(redirect_pc, m_rpc, "model redirect_pc");
        chk(csr_rdata, m_rdata(), "model csr_rdata");
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic do_op(input int code, input int sel, input int wd);
        op_valid = 1; op_code = 3'(code); csr_sel = 2'(sel); csr_wdata = 16'(wd);
        step();
        op_valid = 0; op_code = 0;
    endtask

    task automatic rd(input int sel, input int exp, input string what);
        csr_sel = 2'(sel);
        #1;
        chk(csr_rdata, exp, what);
    endtask

    initial begin
        #200000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state and reset vector
        cur_req = "R1";
        cyc(3);
        chk({redirect_valid, halt}, 0, "R1 outputs in reset");
        rst_n = 1;
        step();
        chk({redirect_valid, flush}, 2'b11, "R1 redirect after release");
        chk(redirect_pc, 16'h0000, "R1 reset vector");
        step();
        chk(redirect_valid, 0, "R1 single pulse");
        rd(0, 1, "R1 status I=1 T=0");

        // R8: CSR write of status, set T=1 I=0
        cur_req = "R8";
        do_op(3, 0, 16'h0002);
        rd(0, 2, "R8 status write");
        rd(3, 0, "R8 unmapped reads zero");

        // R3 / R6: maskable entry
        cur_req = "R6";
        irq_n = 0; next_pc = 16'h1234; insn_boundary = 1;
        step();
        insn_boundary = 0;
        chk({redirect_valid, flush}, 2'b11, "R6 redirect and flush");
        chk(redirect_pc, 16'h0006, "R3 IRQ vector");
        rd(2, 16'h1234, "R6 return PC saved");
        rd(1, 2, "R6 status shadowed");
        rd(0, 3, "R6 entry sets I");
        cur_req = "R3";
        insn_boundary = 1;
        cyc(3);
        insn_boundary = 0;
        chk(redirect_valid, 0, "R3 IRQ masked while I=1");

        // R7: return
        cur_req = "R7";
        irq_n = 1;
        do_op(1, 0, 0);
        chk(redirect_valid, 1, "R7 return redirects");
        chk(redirect_pc, 16'h1234, "R7 return target");
        rd(0, 2, "R7 status restored");

        // R2: NMI edge, unmaskable
        cur_req = "R2";
        do_op(5, 0, 0);
        nmi_n = 0;
        cyc(2);
        next_pc = 16'h0400; insn_boundary = 1;
        step();
        chk(redirect_pc, 16'h0002, "R2 NMI vector with I=1");
        chk(redirect_valid, 1, "R2 NMI taken");
        cyc(2);
        insn_boundary = 0;
        chk(redirect_valid, 0, "R2 low level gives no second entry");
        nmi_n = 1;
        step();

        // R5: priority
        cur_req = "R5";
        do_op(4, 0, 0);
        nmi_n = 0; brk_req = 1; irq_n = 0;
        step();
        insn_boundary = 1;
        step();
        chk(redirect_pc, 16'h0002, "R5 NMI beats BRK and IRQ");
        step();
        chk(redirect_pc, 16'h0004, "R5 BRK beats IRQ, taken with I=1");
        brk_req = 0;
        step();
        chk(redirect_valid, 0, "R5 IRQ masked after entry");
        insn_boundary = 0;
        do_op(4, 0, 0);
        insn_boundary = 1;
        step();
        chk(redirect_pc, 16'h0006, "R5 IRQ last");
        insn_boundary = 0; irq_n = 1; nmi_n = 1;
        step();

        // R4 / R10: sampling only at clean boundaries
        cur_req = "R4";
        do_op(4, 0, 0);
        irq_n = 0;
        cyc(3);
        chk(redirect_valid, 0, "R4 no boundary no entry");
        cur_req = "R10";
        insn_boundary = 1; op_valid = 1; op_code = 0;
        step();
        chk(redirect_valid, 0, "R10 op cycle defers event");
        op_valid = 0;
        step();
        chk(redirect_pc, 16'h0006, "R10 taken at next boundary");
        insn_boundary = 0; irq_n = 1;
        step();

        // R9: clear/set I keep T
        cur_req = "R9";
        do_op(3, 0, 16'h0003);
        do_op(4, 0, 0);
        rd(0, 2, "R9 clear I keeps T");
        do_op(5, 0, 0);
        rd(0, 3, "R9 set I keeps T");

        // R11: wait state
        cur_req = "R11";
        do_op(6, 0, 0);
        chk(halt, 1, "R11 wait raises halt");
        irq_n = 0; brk_req = 1;
        cyc(3);
        chk({halt, redirect_valid}, 2'b10, "R11 masked IRQ and BRK do not wake");
        brk_req = 0;
        do_op(4, 0, 0);
        rd(0, 3, "R11 ops ignored while waiting");
        nmi_n = 0;
        cyc(2);
        chk({halt, redirect_valid}, 2'b01, "R11 NMI wakes");
        chk(redirect_pc, 16'h0002, "R11 NMI wake vector");
        nmi_n = 1; irq_n = 1;
        do_op(4, 0, 0);
        do_op(6, 0, 0);
        irq_n = 0;
        step();
        chk(redirect_pc, 16'h0006, "R11 unmasked IRQ wakes");
        chk(halt, 0, "R11 halt released");
        irq_n = 1;
        step();

        // R12: stop state
        cur_req = "R12";
        do_op(7, 0, 0);
        chk(halt, 1, "R12 stop raises halt");
        nmi_n = 0; brk_req = 1; insn_boundary = 1;
        op_valid = 1; op_code = 1;
        cyc(4);
        op_valid = 0; brk_req = 0; insn_boundary = 0;
        chk({halt, redirect_valid}, 2'b10, "R12 nothing taken while stopped");

        // R13: reset discards the latched NMI (nmi_n held low)
        cur_req = "R13";
        rst_n = 0;
        cyc(2);
        rst_n = 1;
        step();
        chk(redirect_pc, 16'h0000, "R12 reset leaves stop");
        insn_boundary = 1;
        cyc(2);
        insn_boundary = 0;
        chk({halt, redirect_valid}, 0, "R13 pending NMI dropped");
        nmi_n = 1;

        // R14: bit 0 of the return PC
        cur_req = "R14";
        brk_req = 1; insn_boundary = 1; next_pc = 16'h2345;
        step();
        brk_req = 0; insn_boundary = 0;
        chk(redirect_pc, 16'h0004, "R14 BRK entry");
        rd(2, 16'h2344, "R14 odd next_pc stored even");
        do_op(3, 2, 16'hBEEF);
        rd(2, 16'hBEEE, "R14 CSR write drops bit 0");
        cur_req = "R8";
        do_op(3, 1, 16'h0001);
        rd(1, 1, "R8 shadow write");
        do_op(3, 3, 16'hFFFF);
        rd(0, 1, "R8 unmapped write ignored");
        do_op(2, 0, 0);
        rd(0, 1, "R8 CSR read changes nothing");
        cur_req = "R7";
        do_op(1, 0, 0);
        chk(redirect_pc, 16'hBEEE, "R7 return to written shadow");
        rd(0, 1, "R7 status from written shadow");
        cyc(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule